// File: doc/BRIEF.md
# Indexed-Write Multi-CPU Interrupt Router

This block gathers a configurable number of level-sensitive interrupt lines and routes each one to one or more of up to four processors. Software changes state without read-modify-write. It writes a source number to a set register or a clear register. Writing to the global enable registers turns a source on or off for every processor. Writing to one processor's mask registers hides or shows a source for that processor only.

Every source has a routing word that names the processors it may reach. Each processor has a register window with an acknowledge register. Reading that register returns the lowest-numbered source that is asserted, enabled, routed to that processor and unmasked. It returns 1023 when no source qualifies. Reading it changes nothing. A source stays pending only while its input line is high.

By convention, source numbers 0 and 1 are reserved for the summary lines of a doorbell unit. The router itself treats them like any other source. The block has a plain 32-bit read/write register port and one interrupt output per processor.

Top module: `irq_router`

## Requirements
- R1: A read of address 0x000 returns the number of implemented sources in bits [11:2], with every other bit zero.
- R2: Writing a source number in bits [9:0] to address 0x030 enables that source for all processors. Writing a source number to 0x034 disables it. No other source's enable changes.
- R3: Processor c has a window at 0x2000 + 0x100*c. Writing a source number to offset 0x48 of that window masks the source for processor c only. Writing a source number to offset 0x4C unmasks it for processor c only.
- R4: Source n has a routing word at 0x100 + 4*n. Bit c of the word lets the source reach processor c. Reads return the stored bits, and the upper bits read as zero.
- R5: In the same cycle, irq_out[c] is high exactly when at least one source qualifies for processor c. A source qualifies when its input is high, it is enabled, it is routed to c and it is unmasked for c. Nothing is latched.
- R6: A read of offset 0x44 in processor c's window returns the lowest qualifying source number in bits [9:0], or 1023 when none qualifies. The read has no side effect.
- R7: After reset, all enables are clear, all masks are set and all routing words are zero, so every output is low.
- R8: A set or clear write whose source number is not below the source count is ignored.
- R9: Read data is registered and appears in the cycle after the read strobe. It holds until the next read. Reads of unmapped addresses return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| src_lvl | input | NUM_SRC | Level of each interrupt source |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_out | output | NUM_CPUS | Interrupt request for each processor |

## Verification
An interrupt output follows a level change on src_lvl within the same cycle. It follows a register write from the clock edge that takes the write. Acknowledge and other read data are due one edge after the read strobe. The acknowledge value reflects the state before any write taken at that same edge. The bench drives its inputs shortly after each rising edge. A behavioural model updates at the edge, and the bench compares the model with the outputs at the falling edge of every cycle. Each result is therefore checked in exactly the cycle it becomes due.

// File: rtl/irq_router.sv
`timescale 1ns/1ps
module irq_router #(
  parameter int NUM_SRC  = 64,
  parameter int NUM_CPUS = 4,
  parameter int ADDR_W   = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_SRC-1:0]  src_lvl,
  input  logic                bus_wr,
  input  logic                bus_rd,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  output logic [NUM_CPUS-1:0] irq_out
);
  localparam int SW         = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
  localparam int CW         = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1;
  localparam int ROUTE_BASE = 'h100;
  localparam int ROUTE_END  = ROUTE_BASE + 4 * NUM_SRC;
  localparam int CPU_BASE   = 'h2000;
  localparam int CPU_END    = CPU_BASE + 'h100 * NUM_CPUS;
  localparam int EN_SET     = 'h30;
  localparam int EN_CLR     = 'h34;
  localparam logic [7:0] ACK_OFS  = 8'h44;
  localparam logic [7:0] MSET_OFS = 8'h48;
  localparam logic [7:0] MCLR_OFS = 8'h4C;
  localparam logic [9:0] NONE     = 10'h3FF;

  logic [NUM_SRC-1:0]                en;
  logic [NUM_CPUS-1:0][NUM_SRC-1:0] msk;
  logic [NUM_CPUS-1:0]               route [NUM_SRC];
  logic [NUM_CPUS-1:0][9:0]          pick;
  logic [31:0]                       rd_next;

  wire [31:0]   a32       = 32'(bus_addr);
  wire [9:0]    widx      = bus_wdata[9:0];
  wire [SW-1:0] widx_s    = widx[SW-1:0];
  wire          widx_ok   = 32'(widx) < NUM_SRC;
  wire          route_hit = a32 >= ROUTE_BASE && a32 < ROUTE_END && a32[1:0] == 2'b00;
  wire [SW-1:0] ridx      = SW'((a32 - ROUTE_BASE) >> 2);
  wire          cpu_hit   = a32 >= CPU_BASE && a32 < CPU_END;
  wire [CW-1:0] csel      = CW'((a32 - CPU_BASE) >> 8);
  wire [7:0]    creg      = 8'(a32 - CPU_BASE);
  wire          unused_wd = ^bus_wdata[31:10];

  always_ff @(posedge clk) begin
    if (rst) en <= '0;
    else if (bus_wr && widx_ok) begin
      if (a32 == EN_SET)      en[widx_s] <= 1'b1;
      else if (a32 == EN_CLR) en[widx_s] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) msk <= '1;
    else if (bus_wr && cpu_hit && widx_ok) begin
      for (int c = 0; c < NUM_CPUS; c++) begin
        if (csel == CW'(c)) begin
          if (creg == MSET_OFS)      msk[c][widx_s] <= 1'b1;
          else if (creg == MCLR_OFS) msk[c][widx_s] <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int n = 0; n < NUM_SRC; n++) route[n] <= '0;
    end else if (bus_wr && route_hit) begin
      route[ridx] <= bus_wdata[NUM_CPUS-1:0];
    end
  end

  for (genvar c = 0; c < NUM_CPUS; c++) begin : g_cpu
    logic [NUM_SRC-1:0] rcol;
    logic [NUM_SRC-1:0] q;
    logic [9:0]         pk;
    always_comb begin
      for (int n = 0; n < NUM_SRC; n++) rcol[n] = route[n][c];
    end
    assign q = src_lvl & en & rcol & ~msk[c];
    always_comb begin
      pk = NONE;
      for (int n = NUM_SRC - 1; n >= 0; n--)
        if (q[n]) pk = 10'(n);
    end
    assign irq_out[c] = |q;
    assign pick[c]    = pk;
  end

  always_comb begin
    rd_next = '0;
    if (a32 == 0)                          rd_next = 32'(NUM_SRC) << 2;
    else if (route_hit)                    rd_next = 32'(route[ridx]);
    else if (cpu_hit && creg == ACK_OFS)   rd_next = {22'b0, pick[csel]};
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_next;
  end

  // R2
  en_set_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && a32 == EN_SET && widx_ok) |=> en[$past(widx_s)]);
  // R2
  en_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && a32 == EN_CLR && widx_ok) |=> !en[$past(widx_s)]);
  // R8
  idx_range_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && !widx_ok) |=> ($stable(en) && $stable(msk)));
  // R3
  mask_set_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && cpu_hit && csel == '0 && creg == MSET_OFS && widx_ok) |=> msk[0][$past(widx_s)]);
  // R5
  quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (src_lvl == '0) |-> (irq_out == '0));
  // R6
  ack_range_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && cpu_hit && creg == ACK_OFS) |=>
      (bus_rdata[31:10] == '0 && (bus_rdata[9:0] == NONE || 32'(bus_rdata[9:0]) < NUM_SRC)));
  // R7
  reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (irq_out == '0));
endmodule

// File: tb/irq_router_test.sv
`timescale 1ns/1ps
module irq_router_test;
  localparam int N = 64;
  localparam int C = 4;

  logic clk = 0;
  logic rst = 1;
  logic [N-1:0] src_lvl = '0;
  logic bus_wr = 0, bus_rd = 0;
  logic [15:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [C-1:0] irq_out;

  int total = 0, bad = 0;
  bit done = 0, started = 0;

  irq_router #(.NUM_SRC(N), .NUM_CPUS(C), .ADDR_W(16)) uut (
    .clk(clk), .rst(rst), .src_lvl(src_lvl), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_out(irq_out));

  always #5 clk = ~clk;

  bit m_en [N];
  bit m_msk [C][N];
  int m_route [N];
  logic [31:0] m_rdata;
  string m_rlabel = "R7";

  function automatic int m_ack(int c);
    for (int n = 0; n < N; n++)
      if (src_lvl[n] && m_en[n] && m_route[n][c] && !m_msk[c][n]) return n;
    return 1023;
  endfunction

  function automatic int win(int a);
    return (a >= 'h2000 && a < 'h2000 + 'h100 * C) ? (a - 'h2000) / 'h100 : -1;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int n = 0; n < N; n++) begin
        m_en[n] = 0; m_route[n] = 0;
        for (int c = 0; c < C; c++) m_msk[c][n] = 1;
      end
      m_rdata = 0; m_rlabel = "R7";
    end else begin
      int a, d, ix, c;
      a = bus_addr; d = bus_wdata; ix = d & 'h3FF; c = win(a);
      if (bus_rd) begin
        if (a == 0) begin m_rdata = N << 2; m_rlabel = "R1"; end
        else if (a >= 'h100 && a < 'h100 + 4*N && a % 4 == 0) begin
          m_rdata = m_route[(a - 'h100) / 4]; m_rlabel = "R4";
        end else if (c >= 0 && (a & 'hFF) == 'h44) begin
          m_rdata = m_ack(c); m_rlabel = "R6";
        end else begin m_rdata = 0; m_rlabel = "R9"; end
      end
      if (bus_wr) begin
        if (a == 'h30 && ix < N) m_en[ix] = 1;
        else if (a == 'h34 && ix < N) m_en[ix] = 0;
        else if (a >= 'h100 && a < 'h100 + 4*N && a % 4 == 0)
          m_route[(a - 'h100) / 4] = d & ((1 << C) - 1);
        else if (c >= 0 && ix < N && (a & 'hFF) == 'h48) m_msk[c][ix] = 1;
        else if (c >= 0 && ix < N && (a & 'hFF) == 'h4C) m_msk[c][ix] = 0;
      end
    end
  end

  always @(negedge clk) begin
    if (started && !done) begin
      for (int c = 0; c < C; c++) begin
        total++;
        if (irq_out[c] !== (m_ack(c) != 1023)) begin
          bad++;
          $display("FAIL R5 irq_out[%0d] actual=%b expected=%b", c, irq_out[c], m_ack(c) != 1023);
        end
      end
      total++;
      if (bus_rdata !== m_rdata) begin
        bad++;
        $display("FAIL %s rdata actual=%h expected=%h", m_rlabel, bus_rdata, m_rdata);
      end
    end
  end

  task automatic op(bit w, bit r, int a, int d);
    @(posedge clk); #2;
    bus_wr = w; bus_rd = r; bus_addr = 16'(a); bus_wdata = d;
  endtask
  task automatic wr(int a, int d); op(1, 0, a, d); endtask
  task automatic rd(int a);        op(0, 1, a, 0); endtask
  task automatic idle();           op(0, 0, 0, 0); endtask
  function automatic int cw(int c, int r); return 'h2000 + 'h100 * c + r; endfunction

  initial begin
    #1_000_000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    started = 1;
    repeat (3) @(posedge clk);
    #2 rst = 0;
    // R7: masks set, nothing routed: all acks read 1023
    src_lvl = '1;
    for (int c = 0; c < C; c++) rd(cw(c, 'h44));
    // R1
    rd(0);
    // R4 routing words
    wr('h100 + 4*5, 1); wr('h100 + 4*9, 6); wr('h100 + 4*2, 'hFFFF_FFFF);
    rd('h100 + 4*2); rd('h100 + 4*9);
    // R2 enable
    wr('h30, 5); wr('h30, 9); wr('h30, 2);
    // R3 unmask for cpu0 only
    wr(cw(0, 'h4C), 5); wr(cw(0, 'h4C), 9);
    rd(cw(0, 'h44)); rd(cw(1, 'h44));
    wr(cw(0, 'h4C), 2); rd(cw(0, 'h44));
    // R6 no side effect: repeated reads
    rd(cw(0, 'h44)); rd(cw(0, 'h44));
    // R5 level follows input
    src_lvl[2] = 0; rd(cw(0, 'h44));
    src_lvl[5] = 0; idle(); src_lvl[5] = 1; idle();
    // R2 clear enable
    wr('h34, 5); rd(cw(0, 'h44));
    // R3 cpu1 and cpu2
    wr(cw(1, 'h4C), 9); rd(cw(1, 'h44)); rd(cw(2, 'h44));
    wr(cw(1, 'h48), 9); rd(cw(1, 'h44));
    // R8 out-of-range indices
    wr('h30, 64); wr('h30, 1023); wr(cw(0, 'h4C), 100); wr('h34, 'h400 | 9);
    rd(cw(1, 'h44));
    // R9 unmapped reads and hold
    rd('h8); idle(); rd('h3FFC); rd(cw(3, 'h10));
    // mixed random traffic
    for (int i = 0; i < 4000; i++) begin
      int k, a, d;
      k = $urandom_range(0, 9);
      d = $urandom_range(0, 70) | (($urandom_range(0, 7) == 0) ? 'h400 : 0);
      case (k)
        0: a = 0;
        1: a = 'h30;
        2: a = 'h34;
        3, 4: a = 'h100 + 4 * $urandom_range(0, N + 2);
        5: a = cw($urandom_range(0, C - 1), 'h48);
        6: a = cw($urandom_range(0, C - 1), 'h4C);
        7, 8: a = cw($urandom_range(0, C - 1), 'h44);
        default: a = $urandom_range(0, 'h3FFF);
      endcase
      if ($urandom_range(0, 3) == 0) src_lvl = {$urandom, $urandom};
      if ($urandom_range(0, 1) == 0) begin
        if (k >= 3 && k <= 4) d = $urandom;
        wr(a, d);
      end else rd(a);
    end
    idle(); idle();
    @(posedge clk); #1;
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule